// File: doc/BRIEF.md
# Stuffed NRZI Packet Transmitter

This block builds framed packets for a one-wire baseband link and puts them on a single line output, one bit for each pulse of a bit strobe. Every packet has three parts. It opens with a synchronization preamble. A start-of-frame delimiter follows. The packet ends with a fixed number of payload bytes. The payload comes from one of two sources. The first is a byte input with a valid/ready handshake. The second is a built-in 20-stage pseudo-random generator, which is used for bit-error measurements on the link.

The payload is bit-stuffed and then NRZI-coded, so the receiver's clock recovery sees a level change at least once in every six bit periods. While the run control stays high, packets follow one another with no idle bits between them. When the run control is dropped, the packet in flight is finished and the line then holds its level.

The clock, the strobe generation and the analog line driver are outside this block.

Top module: `snrz_pkt_tx`

## Requirements
- R1: While reset is asserted and just after it, `line_out` is 0, `pkt_done` is 0 and `byte_ready` is 0, and the block is idle.
- R2: A packet opens with 16 preamble bits that alternate starting with 1 (1,0,1,0,...). These are followed at once by the delimiter bits 1,0,1,1 in that order. Neither section is stuffed.
- R3: The payload is PAYLOAD_BYTES bytes, each sent least significant bit first and with no gaps while data is held. If `tx_run` is high on the last payload strobe, the next packet's first preamble bit goes out on the very next strobe.
- R4: NRZI coding applies. A 1 bit inverts `line_out` and a 0 bit keeps it. The change appears in the clock cycle after the strobe that carries the bit.
- R5: Inside the payload, once four data 0 bits have been sent in a row, one extra 1 bit is sent before the next payload bit. The zero count restarts at the start of every payload. No extra bit is added after the last payload bit.
- R6: Across consecutive transmitted bit periods, `line_out` never keeps the same level for more than 5 periods.
- R7: With `use_prbs` set, payload bits come from a 20-bit register S. The output bit is S[19], and the next value is {S[18:0], S[19]^S[16]}. S is loaded with 20'h5A5A5 at the start of every packet and steps only on payload bits that are not stuffed.
- R8: `byte_ready` is high only in external-data mode during a packet, and only when the one-byte holding register is empty or its last bit goes out on this strobe. A byte is taken when `byte_valid` and `byte_ready` are both high. In PRBS mode `byte_ready` stays 0.
- R9: `pkt_done` is a one-cycle pulse in the cycle after the strobe that sends the last payload bit.
- R10: The block stays idle until `tx_run` is high. The source mode is latched at the start of each packet, so changing `use_prbs` during a packet has no effect. If `tx_run` is low at the end of a packet, no more bits are sent and `byte_ready` stays 0.
- R11: Each strobe sends at most one bit. `line_out` does not change in a cycle after which no strobe was given.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_stb | input | 1 | Bit strobe: one line bit per high cycle |
| tx_run | input | 1 | Keep starting packets while high |
| use_prbs | input | 1 | 1 selects the internal pseudo-random payload, 0 the byte input |
| byte_data | input | 8 | Payload byte |
| byte_valid | input | 1 | byte_data is valid |
| byte_ready | output | 1 | Block takes the byte this cycle |
| line_out | output | 1 | NRZI-coded line level |
| pkt_done | output | 1 | One-cycle pulse after the last payload bit |

## Verification
The run-length and stuffing properties assume that in external mode a byte is always waiting when a payload data bit is due. If no byte is waiting, that strobe sends nothing and the line is unchanged. The bench meets this assumption by holding `byte_valid` high with a fresh byte after every handshake. The properties also assume that `bit_stb` is not given in the same cycle that `tx_run` moves the block out of idle. The bench meets this by starting every packet with one strobe-free cycle. Bytes of all zeros are mixed into the stimulus so that stuffing happens at both ends of the payload.

// File: rtl/txp_pkg.sv
package txp_pkg;

    // Framer phase: idle, preamble, delimiter, payload
    typedef enum logic [1:0] {
        TXP_IDLE = 2'd0,
        TXP_PRE  = 2'd1,
        TXP_SFD  = 2'd2,
        TXP_PAY  = 2'd3
    } txp_state_e;

endpackage

// File: rtl/txp_prbs.sv
// Fibonacci pattern source: output is the top stage, feedback is top ^ tap.
module txp_prbs #(
    parameter int          WIDTH = 20,
    parameter int          TAP   = 17,
    parameter logic [19:0] SEED  = 20'h5A5A5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic seed_i,
    input  logic adv_i,
    output logic bit_o
);
    localparam logic [WIDTH-1:0] SEED_W = WIDTH'(SEED);

    logic [WIDTH-1:0] lfsr_q, lfsr_d;

    always_comb begin
        lfsr_d = lfsr_q;
        if (seed_i) begin
            lfsr_d = SEED_W;
        end else if (adv_i) begin
            lfsr_d = {lfsr_q[WIDTH-2:0], lfsr_q[WIDTH-1] ^ lfsr_q[TAP-1]};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lfsr_q <= SEED_W;
        else        lfsr_q <= lfsr_d;
    end

    assign bit_o = lfsr_q[WIDTH-1];

endmodule

// File: rtl/txp_byte_buf.sv
// One-byte holding register, shifted out LSB first, refilled on the strobe
// that takes its last bit.
module txp_byte_buf #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable_i,
    input  logic              take_i,
    input  logic [BYTE_W-1:0] byte_data_i,
    input  logic              byte_valid_i,
    output logic              byte_ready_o,
    output logic              avail_o,
    output logic              bit_o
);
    localparam int LW = $clog2(BYTE_W + 1);

    typedef struct packed {
        logic [BYTE_W-1:0] sh;
        logic [LW-1:0]     left;
    } buf_t;

    buf_t r_q, r_d;
    logic last_out;
    logic load;

    assign avail_o      = (r_q.left != '0);
    assign bit_o        = r_q.sh[0];
    assign last_out     = take_i && (r_q.left == LW'(1));
    assign byte_ready_o = enable_i && ((r_q.left == '0) || last_out);
    assign load         = byte_ready_o && byte_valid_i;

    always_comb begin
        r_d = r_q;
        if (take_i && avail_o) begin
            r_d.sh   = r_q.sh >> 1;
            r_d.left = r_q.left - LW'(1);
        end
        if (load) begin
            r_d.sh   = byte_data_i;
            r_d.left = LW'(BYTE_W);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

endmodule

// File: rtl/txp_nrzi.sv
// Line register: a 1 inverts the level, a 0 keeps it.
module txp_nrzi (
    input  logic clk,
    input  logic rst_n,
    input  logic emit_i,
    input  logic bit_i,
    output logic line_o
);
    logic line_q, line_d;

    always_comb begin
        line_d = line_q;
        if (emit_i) line_d = line_q ^ bit_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) line_q <= 1'b0;
        else        line_q <= line_d;
    end

    assign line_o = line_q;

endmodule

// File: rtl/txp_framer.sv
// Packet sequencer: preamble, delimiter, payload with zero-run stuffing.
module txp_framer
    import txp_pkg::*;
#(
    parameter int                  PRE_BITS      = 16,
    parameter int                  SFD_BITS      = 4,
    parameter logic [SFD_BITS-1:0] SFD_CODE      = 4'b1011,
    parameter int                  PAYLOAD_BYTES = 1000,
    parameter int                  STUFF_RUN     = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_stb,
    input  logic tx_run,
    input  logic use_prbs,
    input  logic src_avail_i,
    input  logic src_bit_i,
    output logic emit_o,
    output logic bit_o,
    output logic stuff_o,
    output logic take_o,
    output logic seed_o,
    output logic mode_o,
    output logic active_o,
    output logic done_o
);
    localparam int PAY_BITS = PAYLOAD_BYTES * 8;
    localparam int MAX_CNT  = (PAY_BITS > PRE_BITS) ? PAY_BITS : PRE_BITS;
    localparam int CNT_W    = $clog2(MAX_CNT) + 1;
    localparam int ZW       = $clog2(STUFF_RUN + 1);

    typedef struct packed {
        txp_state_e     state;
        logic [CNT_W-1:0] cnt;
        logic [ZW-1:0]  zeros;
        logic           mode;
        logic           done;
    } fr_t;

    fr_t r_q, r_d;
    logic [SFD_BITS-1:0] sfd_win;
    logic pre_last, sfd_last, pay_last, stuff_due;

    assign pre_last  = (r_q.cnt == CNT_W'(PRE_BITS - 1));
    assign sfd_last  = (r_q.cnt == CNT_W'(SFD_BITS - 1));
    assign pay_last  = (r_q.cnt == CNT_W'(PAY_BITS - 1));
    assign stuff_due = (r_q.zeros == ZW'(STUFF_RUN));

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        emit_o   = 1'b0;
        bit_o    = 1'b0;
        stuff_o  = 1'b0;
        take_o   = 1'b0;
        seed_o   = 1'b0;
        sfd_win  = SFD_CODE << r_q.cnt;
        unique case (r_q.state)
            TXP_IDLE: begin
                if (tx_run) begin
                    r_d.state = TXP_PRE;
                    r_d.cnt   = '0;
                    r_d.mode  = use_prbs;
                    seed_o    = 1'b1;
                end
            end
            TXP_PRE: begin
                if (bit_stb) begin
                    emit_o = 1'b1;
                    bit_o  = ~r_q.cnt[0];
                    if (pre_last) begin
                        r_d.state = TXP_SFD;
                        r_d.cnt   = '0;
                    end else begin
                        r_d.cnt = r_q.cnt + CNT_W'(1);
                    end
                end
            end
            TXP_SFD: begin
                if (bit_stb) begin
                    emit_o = 1'b1;
                    bit_o  = sfd_win[SFD_BITS-1];
                    if (sfd_last) begin
                        r_d.state = TXP_PAY;
                        r_d.cnt   = '0;
                        r_d.zeros = '0;
                    end else begin
                        r_d.cnt = r_q.cnt + CNT_W'(1);
                    end
                end
            end
            TXP_PAY: begin
                if (bit_stb) begin
                    if (stuff_due) begin
                        emit_o    = 1'b1;
                        bit_o     = 1'b1;
                        stuff_o   = 1'b1;
                        r_d.zeros = '0;
                    end else if (src_avail_i) begin
                        emit_o    = 1'b1;
                        take_o    = 1'b1;
                        bit_o     = src_bit_i;
                        r_d.zeros = src_bit_i ? '0 : (r_q.zeros + ZW'(1));
                        if (pay_last) begin
                            r_d.done = 1'b1;
                            r_d.cnt  = '0;
                            if (tx_run) begin
                                r_d.state = TXP_PRE;
                                r_d.mode  = use_prbs;
                                seed_o    = 1'b1;
                            end else begin
                                r_d.state = TXP_IDLE;
                            end
                        end else begin
                            r_d.cnt = r_q.cnt + CNT_W'(1);
                        end
                    end
                end
            end
            default: r_d.state = TXP_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.state <= TXP_IDLE;
            r_q.cnt   <= '0;
            r_q.zeros <= '0;
            r_q.mode  <= 1'b0;
            r_q.done  <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign mode_o   = r_q.mode;
    assign active_o = (r_q.state != TXP_IDLE);
    assign done_o   = r_q.done;

endmodule

// File: rtl/snrz_pkt_tx.sv
module snrz_pkt_tx #(
    parameter int          PAYLOAD_BYTES = 1000,
    parameter int          PRE_BITS      = 16,
    parameter int          STUFF_RUN     = 4,
    parameter int          PRBS_W        = 20,
    parameter int          PRBS_TAP      = 17,
    parameter logic [19:0] PRBS_SEED     = 20'h5A5A5,
    parameter int          BYTE_W        = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_stb,
    input  logic              tx_run,
    input  logic              use_prbs,
    input  logic [BYTE_W-1:0] byte_data,
    input  logic              byte_valid,
    output logic              byte_ready,
    output logic              line_out,
    output logic              pkt_done
);
    logic emit, tx_bit, stuff, take, seed, mode_q, active;
    logic buf_avail, buf_bit, prbs_bit;
    logic src_avail, src_bit;

    assign src_avail = mode_q ? 1'b1 : buf_avail;
    assign src_bit   = mode_q ? prbs_bit : buf_bit;

    txp_framer #(
        .PRE_BITS      (PRE_BITS),
        .SFD_BITS      (4),
        .SFD_CODE      (4'b1011),
        .PAYLOAD_BYTES (PAYLOAD_BYTES),
        .STUFF_RUN     (STUFF_RUN)
    ) i_framer (
        .clk         (clk),
        .rst_n       (rst_n),
        .bit_stb     (bit_stb),
        .tx_run      (tx_run),
        .use_prbs    (use_prbs),
        .src_avail_i (src_avail),
        .src_bit_i   (src_bit),
        .emit_o      (emit),
        .bit_o       (tx_bit),
        .stuff_o     (stuff),
        .take_o      (take),
        .seed_o      (seed),
        .mode_o      (mode_q),
        .active_o    (active),
        .done_o      (pkt_done)
    );

    txp_byte_buf #(.BYTE_W(BYTE_W)) i_buf (
        .clk          (clk),
        .rst_n        (rst_n),
        .enable_i     (active && !mode_q),
        .take_i       (take && !mode_q),
        .byte_data_i  (byte_data),
        .byte_valid_i (byte_valid),
        .byte_ready_o (byte_ready),
        .avail_o      (buf_avail),
        .bit_o        (buf_bit)
    );

    txp_prbs #(.WIDTH(PRBS_W), .TAP(PRBS_TAP), .SEED(PRBS_SEED)) i_prbs (
        .clk    (clk),
        .rst_n  (rst_n),
        .seed_i (seed),
        .adv_i  (take && mode_q),
        .bit_o  (prbs_bit)
    );

    txp_nrzi i_nrzi (
        .clk    (clk),
        .rst_n  (rst_n),
        .emit_i (emit),
        .bit_i  (tx_bit),
        .line_o (line_out)
    );

endmodule

// File: rtl/snrz_pkt_tx_chk.sv
module snrz_pkt_tx_chk (
    input logic clk,
    input logic rst_n,
    input logic bit_stb,
    input logic line_out,
    input logic pkt_done,
    input logic byte_ready,
    input logic emit,
    input logic stuff,
    input logic mode_q,
    input logic active
);
    // Length of the current run of equal line levels over sent bit periods
    logic       pend_q, last_q;
    logic [2:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
            last_q <= 1'b0;
            run_q  <= 3'd1;
        end else begin
            pend_q <= emit;
            if (pend_q) begin
                last_q <= line_out;
                if (line_out == last_q) begin
                    if (run_q != 3'd7) run_q <= run_q + 3'd1;
                end else begin
                    run_q <= 3'd1;
                end
            end
        end
    end

    AST_HOLD_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_stb |=> $stable(line_out)); // R11
    AST_RUN_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        run_q <= 3'd5); // R6
    AST_STUFF_TOGGLES: assert property (@(posedge clk) disable iff (!rst_n)
        (emit && stuff) |=> (line_out != $past(line_out))); // R5
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_done |=> !pkt_done); // R9
    AST_DONE_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_done |-> $past(bit_stb)); // R9
    AST_PRBS_NO_READY: assert property (@(posedge clk) disable iff (!rst_n)
        mode_q |-> !byte_ready); // R8
    AST_IDLE_NO_READY: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> !byte_ready); // R10

endmodule

bind snrz_pkt_tx snrz_pkt_tx_chk i_snrz_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bit_stb    (bit_stb),
    .line_out   (line_out),
    .pkt_done   (pkt_done),
    .byte_ready (byte_ready),
    .emit       (emit),
    .stuff      (stuff),
    .mode_q     (mode_q),
    .active     (active)
);

// File: tb/test_snrz_pkt_tx.sv
`timescale 1ns/1ps
module test_snrz_pkt_tx;
    localparam int PB = 4;
    localparam logic [19:0] SEED = 20'h5A5A5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bit_stb = 1'b0, tx_run = 1'b0, use_prbs = 1'b0;
    logic [7:0] byte_data = 8'h00;
    logic byte_valid = 1'b0;
    logic byte_ready, line_out, pkt_done;

    always #10 clk = ~clk;

    snrz_pkt_tx #(.PAYLOAD_BYTES(PB)) i_snrz_pkt_tx (
        .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .tx_run(tx_run),
        .use_prbs(use_prbs), .byte_data(byte_data), .byte_valid(byte_valid),
        .byte_ready(byte_ready), .line_out(line_out), .pkt_done(pkt_done)
    );

    int n_checks = 0, n_fail = 0;
    bit finished = 1'b0;
    logic [7:0] mem [0:63];
    int feed_idx = 0, exp_byte = 0;
    bit rx_bits [0:1023];
    bit exp_bits [0:1023];
    int rx_n = 0, exp_n = 0;
    int done_at [0:7];
    int done_n = 0;
    int hold_err = 0;
    int rdy_seen = 0;
    int line_moves = 0;
    logic prev_line = 1'b0;
    bit rec = 1'b0;

    task automatic check(input bit ok, input string req, input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // One clock: drive at negedge, sample at the following negedge
    task automatic step(input logic en);
        bit fire;
        bit_stb    = en;
        byte_valid = 1'b1;
        byte_data  = mem[feed_idx];
        #1;
        fire = byte_valid && byte_ready;
        if (byte_ready) rdy_seen++;
        @(posedge clk);
        if (fire) feed_idx++;
        @(negedge clk);
        bit_stb = 1'b0;
        if (!en && line_out != prev_line) hold_err++;
        if (line_out != prev_line) line_moves++;
        if (en && rec) begin
            rx_bits[rx_n] = line_out ^ prev_line;
            rx_n++;
        end
        if (pkt_done) begin
            done_at[done_n] = rx_n;
            done_n++;
        end
        prev_line = line_out;
    endtask

    task automatic push(input bit b);
        exp_bits[exp_n] = b;
        exp_n++;
    endtask

    task automatic add_packet(input bit prbs);
        int zeros;
        logic [19:0] s;
        logic [7:0] by;
        bit b;
        zeros = 0;
        s = SEED;
        for (int i = 0; i < 16; i++) push(i % 2 == 0);
        push(1); push(0); push(1); push(1);
        for (int k = 0; k < PB; k++) begin
            by = 8'h00;
            if (!prbs) begin
                by = mem[exp_byte];
                exp_byte++;
            end
            for (int j = 0; j < 8; j++) begin
                if (prbs) begin
                    b = s[19];
                    s = {s[18:0], s[19] ^ s[16]};
                end else begin
                    b = by[j];
                end
                if (zeros == 4) begin
                    push(1);
                    zeros = 0;
                end
                push(b);
                zeros = b ? 0 : zeros + 1;
            end
        end
    endtask

    function automatic int mismatches(input int lo, input int hi);
        int m = 0;
        for (int i = lo; i < hi; i++) if (rx_bits[i] != exp_bits[i]) m++;
        return m;
    endfunction

    function automatic int max_zero_run();
        int m = 0, c = 0;
        for (int i = 0; i < rx_n; i++) begin
            c = rx_bits[i] ? 0 : c + 1;
            if (c > m) m = c;
        end
        return m;
    endfunction

    task automatic clear_rec();
        rx_n = 0; exp_n = 0; done_n = 0; hold_err = 0; rdy_seen = 0;
    endtask

    task automatic run_until(input int target);
        for (int g = 0; g < 600 && done_n < target; g++) step(1'b1);
    endtask

    task automatic t_reset();
        check(line_out == 1'b0, "R1 line_out after reset", line_out, 0);
        check(pkt_done == 1'b0, "R1 pkt_done after reset", pkt_done, 0);
        check(byte_ready == 1'b0, "R1 byte_ready after reset", byte_ready, 0);
        step(1'b1);
        check(line_out == 1'b0, "R10 no bits while idle", line_out, 0);
    endtask

    task automatic t_single_ext();
        int len;
        clear_rec();
        use_prbs = 1'b0;
        add_packet(1'b0);
        tx_run = 1'b1;
        rec = 1'b1;
        step(1'b0);
        tx_run = 1'b0;
        step(1'b1);
        check(line_out == 1'b1, "R4 first 1 bit inverts line", line_out, 1);
        step(1'b1);
        check(line_out == 1'b1, "R4 0 bit keeps line", line_out, 1);
        run_until(1);
        rec = 1'b0;
        len = exp_n;
        check(mismatches(0, 20) == 0, "R2 preamble and delimiter", mismatches(0, 20), 0);
        check(mismatches(20, len) == 0, "R3 external payload LSB first", mismatches(20, len), 0);
        check(rx_n == len, "R5 stuffed length of packet", rx_n, len);
        check(done_n == 1 && done_at[0] == len, "R9 done after last payload bit", done_at[0], len);
        check(max_zero_run() <= 4, "R6 line run limit", max_zero_run() + 1, 5);
        line_moves = 0;
        for (int i = 0; i < 12; i++) step(1'b1);
        check(line_moves == 0 && done_n == 1, "R10 idle after run dropped", line_moves, 0);
        check(rdy_seen > 0, "R8 bytes requested in external mode", rdy_seen, 1);
    endtask

    task automatic t_back_to_back();
        int len;
        clear_rec();
        use_prbs = 1'b0;
        add_packet(1'b0);
        add_packet(1'b0);
        tx_run = 1'b1;
        rec = 1'b1;
        step(1'b0);
        run_until(1);
        tx_run = 1'b0;
        run_until(2);
        rec = 1'b0;
        len = exp_n;
        check(done_n == 2, "R3 two packets sent", done_n, 2);
        check(mismatches(0, len) == 0, "R3 second packet follows with no gap", mismatches(0, len), 0);
        check(rx_n == len, "R3 back-to-back stream length", rx_n, len);
        check(max_zero_run() <= 4, "R6 line run limit across packets", max_zero_run() + 1, 5);
    endtask

    task automatic t_prbs();
        int len;
        clear_rec();
        use_prbs = 1'b1;
        add_packet(1'b1);
        add_packet(1'b1);
        tx_run = 1'b1;
        rec = 1'b1;
        step(1'b0);
        run_until(1);
        tx_run = 1'b0;
        run_until(2);
        rec = 1'b0;
        use_prbs = 1'b0;
        len = exp_n;
        check(mismatches(0, len) == 0, "R7 pattern payload, reseeded per packet", mismatches(0, len), 0);
        check(rx_n == len, "R7 pattern stream length", rx_n, len);
        check(rdy_seen == 0, "R8 byte_ready low in pattern mode", rdy_seen, 0);
    endtask

    task automatic t_gapped();
        int len;
        clear_rec();
        use_prbs = 1'b0;
        add_packet(1'b0);
        tx_run = 1'b1;
        rec = 1'b1;
        step(1'b0);
        tx_run = 1'b0;
        for (int g = 0; g < 300 && done_n < 1; g++) begin
            if (g == 30) use_prbs = 1'b1;
            step(1'b1);
            step(1'b0);
            step(1'b0);
        end
        rec = 1'b0;
        use_prbs = 1'b0;
        len = exp_n;
        check(hold_err == 0, "R11 line stable without strobe", hold_err, 0);
        check(mismatches(0, len) == 0 && rx_n == len, "R10 mode change mid-packet ignored", mismatches(0, len), 0);
    endtask

    initial begin
        for (int i = 0; i < 64; i++)
            mem[i] = (i % 3 == 1) ? 8'h00 : 8'((i * 59) ^ 8'h5C);
        repeat (3) @(negedge clk);
        t_reset_pre: begin
            check(line_out == 1'b0 && byte_ready == 1'b0, "R1 state during reset", line_out, 0);
        end
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_single_ext();
        t_back_to_back();
        t_prbs();
        t_gapped();
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        finished = 1'b1;
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

endmodule